// File: doc/BRIEF.md
# Address Transition Energy Monitor

This block watches a memory address bus on a fast monitor clock and estimates the energy spent by address-line switching that happens outside of, or alongside, memory accesses. It registers the address once per cycle, finds the bits that rose or fell, and charges a programmable cost for each edge. Some bits of the row and column fields sit in correlated decoder groups of two or three bits. For each such group a small table holds one energy value per bit pattern. A group is charged the table value of a new pattern only after that pattern has stayed on the bus for a programmable number of cycles, so short glitches and patterns that revert cost nothing beyond their edges.

Each group runs a two-state machine. In `GS_SETTLED` the group's pattern equals the last pattern it was charged for. A different pattern moves it to `GS_PENDING` (transition *detect*), or charges at once when the hold time is 0 or 1 (transition *instant*). In `GS_PENDING` the candidate pattern is counted. The group returns to `GS_SETTLED` with a charge when the count reaches the hold time (transition *mature*), or without a charge when the pattern goes back to the charged value (transition *revert*). Any other pattern restarts the count with a new candidate (transition *retarget*).

Software-side configuration arrives through one write port, which loads the edge costs, the group tables and the hold time. Group membership is a per-bit enable plus a per-bit group index. Each cycle the block outputs the energy increment and a wrapping running total.

Top module: `addr_trans_energy`

## Requirements
- R1: Every 0-to-1 edge of bit b of the registered address adds that bit's rise cost to `energy_incr`, with no stability filter. The cost shows up two clock edges after `addr_in` changes.
- R2: Every 1-to-0 edge of bit b adds that bit's fall cost, with the same timing as R1.
- R3: Bit b belongs to group `bit_grp_idx[3b+2:3b]` when `bit_grp_en[b]` is 1. A group's pattern is built from its members in ascending bit order, so the lowest member is pattern bit 0. Members beyond the third are ignored. Bits with the enable at 0 cost only their edges.
- R4: When a group's pattern changes to value p and stays there for the hold time, table entry `g*8+p` is added exactly once.
- R5: A pattern that lasts fewer cycles than the hold time is not charged. A pattern that returns to the last charged value before the hold time is reached adds no group energy.
- R6: The hold time resets to 2. A hold time of 0 or 1 charges a new pattern in the first cycle it is seen.
- R7: A write with `wr_en` high loads the value selected by `wr_kind`: 0 sets the rise cost of bit `wr_idx`, 1 sets the fall cost of bit `wr_idx`, 2 sets group table entry `wr_idx` (which is `g*8+pattern`), and 3 sets the hold time from the low data bits. The new value is used from the next cycle on, and a write adds no energy by itself.
- R8: Reset clears the increment, the total, all costs and all tables. Every cycle, `energy_total` grows by the `energy_incr` of that cycle and wraps on overflow.
- R9: With hold time H ≥ 1, a group charge appears in `energy_incr` H+1 clock edges after `addr_in` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | Address bus being watched |
| bit_grp_en | input | ADDR_W | Per-bit group membership enable |
| bit_grp_idx | input | ADDR_W*GIW | Per-bit group number, GIW bits per address bit |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 2 | Write target: rise, fall, table, hold |
| wr_idx | input | IDX_W | Bit number or table entry |
| wr_data | input | E_W | Value to write |
| energy_incr | output | SUM_W | Energy charged in the previous cycle |
| energy_total | output | ACC_W | Wrapping accumulated energy |

## Verification
If a group machine holds a wrong charged pattern or a wrong candidate count, the port effect is a table value appearing one or more cycles early or late. It can also appear as a value charged for a glitch, or as a charge missing after a revert. Both kinds of fault change `energy_incr` within H+1 cycles of the address change and leave a lasting offset in `energy_total`. A wrong edge cost or a wrong registered address shows up in `energy_incr` two cycles after the address moves. Directed scenarios therefore sample the increment in each cycle of those windows and compare the total against a running expected sum.

// File: rtl/ate_pkg.sv
package ate_pkg;
    typedef enum logic {
        GS_SETTLED = 1'b0,
        GS_PENDING = 1'b1
    } grp_state_t;

    typedef enum logic [1:0] {
        WK_RISE  = 2'd0,
        WK_FALL  = 2'd1,
        WK_TABLE = 2'd2,
        WK_HOLD  = 2'd3
    } wr_kind_t;

    localparam int GRP_MEMBERS_MAX = 3;
    localparam int PAT_SLOTS       = 8;
endpackage

// File: rtl/ate_cost_store.sv
module ate_cost_store
    import ate_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int N_GRP    = 8,
    parameter int E_W      = 8,
    parameter int HOLD_W   = 4,
    parameter int HOLD_RST = 2,
    parameter int IDX_W    = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_kind,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [E_W-1:0]                wr_data,
    output logic [ADDR_W*E_W-1:0]         rise_cost,
    output logic [ADDR_W*E_W-1:0]         fall_cost,
    output logic [N_GRP*PAT_SLOTS*E_W-1:0] grp_tab,
    output logic [HOLD_W-1:0]             hold_q
);
    localparam int TAB_N = N_GRP * PAT_SLOTS;

    logic [E_W-1:0] rise_q [ADDR_W];
    logic [E_W-1:0] fall_q [ADDR_W];
    logic [E_W-1:0] tab_q  [TAB_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ADDR_W; i++) begin
                rise_q[i] <= '0;
                fall_q[i] <= '0;
            end
            for (int i = 0; i < TAB_N; i++) begin
                tab_q[i] <= '0;
            end
            hold_q <= HOLD_W'(HOLD_RST);
        end else if (wr_en) begin
            unique case (wr_kind_t'(wr_kind))
                WK_RISE: begin
                    for (int i = 0; i < ADDR_W; i++)
                        if (int'(wr_idx) == i) rise_q[i] <= wr_data;
                end
                WK_FALL: begin
                    for (int i = 0; i < ADDR_W; i++)
                        if (int'(wr_idx) == i) fall_q[i] <= wr_data;
                end
                WK_TABLE: begin
                    for (int i = 0; i < TAB_N; i++)
                        if (int'(wr_idx) == i) tab_q[i] <= wr_data;
                end
                WK_HOLD: hold_q <= wr_data[HOLD_W-1:0];
            endcase
        end
    end

    for (genvar b = 0; b < ADDR_W; b++) begin : g_bitcost
        assign rise_cost[b*E_W +: E_W] = rise_q[b];
        assign fall_cost[b*E_W +: E_W] = fall_q[b];
    end

    for (genvar t = 0; t < TAB_N; t++) begin : g_tab
        assign grp_tab[t*E_W +: E_W] = tab_q[t];
    end
endmodule

// File: rtl/ate_edge_cost.sv
module ate_edge_cost #(
    parameter int ADDR_W = 8,
    parameter int E_W    = 8,
    parameter int SUM_W  = 13
) (
    input  logic [ADDR_W-1:0]     addr_cur,
    input  logic [ADDR_W-1:0]     addr_prev,
    input  logic [ADDR_W*E_W-1:0] rise_cost,
    input  logic [ADDR_W*E_W-1:0] fall_cost,
    output logic [SUM_W-1:0]      edge_sum
);
    always_comb begin
        edge_sum = '0;
        for (int b = 0; b < ADDR_W; b++) begin
            if (addr_cur[b] && !addr_prev[b])
                edge_sum = edge_sum + SUM_W'(rise_cost[b*E_W +: E_W]);
            if (!addr_cur[b] && addr_prev[b])
                edge_sum = edge_sum + SUM_W'(fall_cost[b*E_W +: E_W]);
        end
    end
endmodule

// File: rtl/ate_group_fsm.sv
module ate_group_fsm
    import ate_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int E_W    = 8,
    parameter int GIW    = 3,
    parameter int HOLD_W = 4,
    parameter int GID    = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr_cur,
    input  logic [ADDR_W-1:0]         grp_en,
    input  logic [ADDR_W*GIW-1:0]     grp_idx,
    input  logic [PAT_SLOTS*E_W-1:0]  table_row,
    input  logic [HOLD_W-1:0]         hold_q,
    output logic [E_W-1:0]            charge
);
    grp_state_t        state_q, state_d;
    logic [2:0]        pat;
    logic [2:0]        slot;
    logic [2:0]        seen_q, seen_d;
    logic [2:0]        cand_q, cand_d;
    logic [HOLD_W-1:0] cnt_q, cnt_d;
    logic [HOLD_W:0]   hold_eff;
    logic [HOLD_W:0]   cnt_inc;
    logic              fire;
    logic [2:0]        fire_pat;

    // collect up to three member bits, lowest address bit first
    always_comb begin
        pat  = '0;
        slot = '0;
        for (int b = 0; b < ADDR_W; b++) begin
            if (grp_en[b] && (grp_idx[b*GIW +: GIW] == GIW'(GID)) &&
                (slot < 3'(GRP_MEMBERS_MAX))) begin
                pat[slot[1:0]] = addr_cur[b];
                slot = slot + 3'd1;
            end
        end
    end

    assign hold_eff = (hold_q == '0) ? (HOLD_W+1)'(1) : {1'b0, hold_q};
    assign cnt_inc  = {1'b0, cnt_q} + (HOLD_W+1)'(1);

    always_comb begin
        state_d  = state_q;
        seen_d   = seen_q;
        cand_d   = cand_q;
        cnt_d    = cnt_q;
        fire     = 1'b0;
        fire_pat = pat;
        unique case (state_q)
            GS_SETTLED: begin
                if (pat != seen_q) begin
                    if (hold_eff <= (HOLD_W+1)'(1)) begin
                        fire   = 1'b1;
                        seen_d = pat;
                    end else begin
                        state_d = GS_PENDING;
                        cand_d  = pat;
                        cnt_d   = HOLD_W'(1);
                    end
                end
            end
            GS_PENDING: begin
                if (pat == cand_q) begin
                    if (cnt_inc >= hold_eff) begin
                        fire     = 1'b1;
                        fire_pat = cand_q;
                        seen_d   = cand_q;
                        state_d  = GS_SETTLED;
                    end else begin
                        cnt_d = cnt_inc[HOLD_W-1:0];
                    end
                end else if (pat == seen_q) begin
                    state_d = GS_SETTLED;
                end else if (hold_eff <= (HOLD_W+1)'(1)) begin
                    fire    = 1'b1;
                    seen_d  = pat;
                    state_d = GS_SETTLED;
                end else begin
                    cand_d = pat;
                    cnt_d  = HOLD_W'(1);
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_SETTLED;
            seen_q  <= '0;
            cand_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            seen_q  <= seen_d;
            cand_q  <= cand_d;
            cnt_q   <= cnt_d;
        end
    end

    // output
    always_comb begin
        charge = '0;
        if (fire)
            charge = table_row[int'(fire_pat)*E_W +: E_W];
    end
endmodule

// File: rtl/addr_trans_energy.sv
module addr_trans_energy
    import ate_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int N_GRP    = 8,
    parameter int GIW      = 3,
    parameter int E_W      = 8,
    parameter int HOLD_W   = 4,
    parameter int HOLD_RST = 2,
    parameter int ACC_W    = 32,
    localparam int TAB_N   = N_GRP * PAT_SLOTS,
    localparam int IDX_W   = $clog2((TAB_N > ADDR_W) ? TAB_N : ADDR_W),
    localparam int SUM_W   = E_W + $clog2(ADDR_W + N_GRP) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr_in,
    input  logic [ADDR_W-1:0]     bit_grp_en,
    input  logic [ADDR_W*GIW-1:0] bit_grp_idx,
    input  logic                  wr_en,
    input  logic [1:0]            wr_kind,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [E_W-1:0]        wr_data,
    output logic [SUM_W-1:0]      energy_incr,
    output logic [ACC_W-1:0]      energy_total
);
    logic [ADDR_W-1:0]            addr_q, addr_p;
    logic [ADDR_W*E_W-1:0]        rise_cost, fall_cost;
    logic [TAB_N*E_W-1:0]         grp_tab;
    logic [HOLD_W-1:0]            hold_q;
    logic [SUM_W-1:0]             edge_sum;
    logic [E_W-1:0]               grp_charge [N_GRP];
    logic [SUM_W-1:0]             cycle_sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            addr_p <= '0;
        end else begin
            addr_q <= addr_in;
            addr_p <= addr_q;
        end
    end

    ate_cost_store #(
        .ADDR_W(ADDR_W), .N_GRP(N_GRP), .E_W(E_W),
        .HOLD_W(HOLD_W), .HOLD_RST(HOLD_RST), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .rise_cost(rise_cost), .fall_cost(fall_cost),
        .grp_tab(grp_tab), .hold_q(hold_q)
    );

    ate_edge_cost #(.ADDR_W(ADDR_W), .E_W(E_W), .SUM_W(SUM_W)) u_edges (
        .addr_cur(addr_q), .addr_prev(addr_p),
        .rise_cost(rise_cost), .fall_cost(fall_cost),
        .edge_sum(edge_sum)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        ate_group_fsm #(
            .ADDR_W(ADDR_W), .E_W(E_W), .GIW(GIW), .HOLD_W(HOLD_W), .GID(g)
        ) u_fsm (
            .clk(clk), .rst_n(rst_n),
            .addr_cur(addr_q),
            .grp_en(bit_grp_en), .grp_idx(bit_grp_idx),
            .table_row(grp_tab[g*PAT_SLOTS*E_W +: PAT_SLOTS*E_W]),
            .hold_q(hold_q),
            .charge(grp_charge[g])
        );
    end

    always_comb begin
        cycle_sum = edge_sum;
        for (int g = 0; g < N_GRP; g++)
            cycle_sum = cycle_sum + SUM_W'(grp_charge[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            energy_incr  <= '0;
            energy_total <= '0;
        end else begin
            energy_incr  <= cycle_sum;
            energy_total <= energy_total + ACC_W'(cycle_sum);
        end
    end
endmodule

// File: rtl/ate_checker.sv
module ate_checker #(
    parameter int ADDR_W   = 8,
    parameter int HOLD_W   = 4,
    parameter int HOLD_RST = 2,
    parameter int SUM_W    = 13,
    parameter int ACC_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_q,
    input logic [ADDR_W-1:0] addr_p,
    input logic [SUM_W-1:0]  edge_sum,
    input logic              wr_en,
    input logic [1:0]        wr_kind,
    input logic [HOLD_W-1:0] wr_hold_val,
    input logic [HOLD_W-1:0] hold_q,
    input logic [SUM_W-1:0]  energy_incr,
    input logic [ACC_W-1:0]  energy_total
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_TOTAL_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> energy_total == $past(energy_total) + ACC_W'(energy_incr))
        else $error("total does not follow increment"); // R8

    AST_NO_EDGE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q == addr_p) |-> edge_sum == '0)
        else $error("edge energy without a bit change"); // R1

    AST_HOLD_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> hold_q == HOLD_W'(HOLD_RST))
        else $error("hold time not at its reset value"); // R6

    AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == 2'd3) |=> hold_q == $past(wr_hold_val))
        else $error("hold write not applied"); // R7
endmodule

bind addr_trans_energy ate_checker #(
    .ADDR_W(ADDR_W), .HOLD_W(HOLD_W), .HOLD_RST(HOLD_RST),
    .SUM_W(SUM_W), .ACC_W(ACC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .addr_q(addr_q), .addr_p(addr_p), .edge_sum(edge_sum),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_hold_val(wr_data[HOLD_W-1:0]),
    .hold_q(hold_q),
    .energy_incr(energy_incr), .energy_total(energy_total)
);

// File: tb/addr_trans_energy_test.sv
`timescale 1ns/1ps
module addr_trans_energy_test;
    localparam int ADDR_W = 8;
    localparam int GIW    = 3;
    localparam int E_W    = 8;
    localparam int IDX_W  = 6;
    localparam int SUM_W  = 13;
    localparam int ACC_W  = 32;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [ADDR_W-1:0]     addr_in = '0;
    logic [ADDR_W-1:0]     bit_grp_en = '0;
    logic [ADDR_W*GIW-1:0] bit_grp_idx = '0;
    logic                  wr_en = 1'b0;
    logic [1:0]            wr_kind = '0;
    logic [IDX_W-1:0]      wr_idx = '0;
    logic [E_W-1:0]        wr_data = '0;
    logic [SUM_W-1:0]      energy_incr;
    logic [ACC_W-1:0]      energy_total;

    int n_checks = 0;
    int n_errors = 0;
    int exp_total = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    addr_trans_energy uut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .bit_grp_en(bit_grp_en), .bit_grp_idx(bit_grp_idx),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .energy_incr(energy_incr), .energy_total(energy_total)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(int kind, int idx, int data);
        wr_en   = 1'b1;
        wr_kind = 2'(kind);
        wr_idx  = IDX_W'(idx);
        wr_data = E_W'(data);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic set_member(int b, bit en, int g);
        bit_grp_en[b] = en;
        bit_grp_idx[b*GIW +: GIW] = GIW'(g);
    endtask

    task automatic check_total(string req);
        check(req, int'(energy_total), exp_total);
    endtask

    // rise cost b+1, fall cost 16+b, table g*8+p holds 100+10g+p
    task automatic t_reset_and_config();
        check("R8 reset incr", int'(energy_incr), 0);
        check("R8 reset total", int'(energy_total), 0);
        set_member(1, 1, 0); set_member(2, 1, 0);
        set_member(4, 1, 1); set_member(5, 1, 1); set_member(6, 1, 1);
        for (int b = 0; b < ADDR_W; b++) begin
            write_cfg(0, b, b + 1);
            write_cfg(1, b, 16 + b);
        end
        for (int g = 0; g < 3; g++)
            for (int p = 0; p < 8; p++)
                write_cfg(2, g*8 + p, 100 + 10*g + p);
        tick();
        check("R7 writes add no energy incr", int'(energy_incr), 0);
        check_total("R7 writes add no energy total");
    endtask

    task automatic t_block_bit();
        addr_in[3] = 1'b1;
        tick(); check("R1 no cost before latency", int'(energy_incr), 0);
        tick(); check("R1 rise cost bit3", int'(energy_incr), 4);
        tick(); check("R3 ungrouped bit no group charge", int'(energy_incr), 0);
        addr_in[3] = 1'b0;
        tick(); tick(); check("R2 fall cost bit3", int'(energy_incr), 19);
        tick();
        exp_total += 23;
        check_total("R8 total after block bit");
    endtask

    task automatic t_group_settle();
        addr_in[1] = 1'b1;
        tick(); check("R9 t1 incr", int'(energy_incr), 0);
        tick(); check("R1 rise bit1 before group", int'(energy_incr), 2);
        tick(); check("R4 R6 group0 pattern1 at default hold", int'(energy_incr), 101);
        tick(); check("R4 charged once", int'(energy_incr), 0);
        exp_total += 103;
        check_total("R8 total after settle");
    endtask

    task automatic t_transient();
        addr_in[2] = 1'b1;
        tick();
        addr_in[1] = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        exp_total += 3 + 17 + 102;
        check_total("R5 one-cycle pattern3 not charged");
    endtask

    task automatic t_revert();
        addr_in[2] = 1'b0;
        tick();
        addr_in[2] = 1'b1;
        for (int i = 0; i < 5; i++) tick();
        exp_total += 18 + 3;
        check_total("R5 revert to charged pattern free");
    endtask

    task automatic t_hold_prog();
        write_cfg(3, 0, 4);
        addr_in[4] = 1'b1;
        addr_in[6] = 1'b1;
        tick(); check("R9 hold4 t1", int'(energy_incr), 0);
        tick(); check("R1 rise bits4 and 6", int'(energy_incr), 12);
        tick(); check("R6 hold4 t3 no charge", int'(energy_incr), 0);
        tick(); check("R9 hold4 t4 no charge", int'(energy_incr), 0);
        tick(); check("R9 R3 hold4 group1 pattern5", int'(energy_incr), 115);
        tick();
        exp_total += 127;
        check_total("R8 total after hold4");
    endtask

    task automatic t_hold_zero();
        write_cfg(3, 0, 0);
        addr_in[6] = 1'b0;
        tick(); tick();
        check("R6 hold0 charges with edge", int'(energy_incr), 22 + 111);
        tick();
        exp_total += 133;
        check_total("R8 total after hold0");
    endtask

    task automatic t_extra_member();
        set_member(7, 1, 1);
        tick();
        addr_in[7] = 1'b1;
        tick(); tick();
        check("R3 fourth member edge only", int'(energy_incr), 8);
        tick();
        check("R3 fourth member no group charge", int'(energy_incr), 0);
        exp_total += 8;
        check_total("R3 total after fourth member");
    endtask

    task automatic t_two_groups();
        set_member(0, 1, 2);
        set_member(3, 1, 2);
        tick();
        addr_in[0] = 1'b1;
        addr_in[1] = 1'b1;
        tick(); tick();
        check("R4 R3 two groups same cycle", int'(energy_incr), 3 + 103 + 121);
        tick();
        exp_total += 227;
        check_total("R8 total after two groups");
    endtask

    task automatic t_table_rewrite();
        write_cfg(2, 16, 50);
        addr_in[0] = 1'b0;
        tick(); tick();
        check("R7 rewritten table entry used", int'(energy_incr), 16 + 50);
        tick();
        exp_total += 66;
        check_total("R8 final total");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset_and_config();
        t_block_bit();
        t_group_settle();
        t_transient();
        t_revert();
        t_hold_prog();
        t_hold_zero();
        t_extra_member();
        t_two_groups();
        t_table_rewrite();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule